// File: doc/BRIEF.md
# Fractional Prescaled Baud Clock Generator

This block produces the timing ticks for a serial line from one free-running input clock. The input clock first passes through an optional fractional prescaler whose ratio is set in eighths. Its output feeds a 16-bit baud divisor, which produces a sample tick. An oversampling counter then turns every 4, 8 or 16 sample ticks into one bit tick. The prescaler lets one fixed oscillator reach both standard and unusual bit rates with small error.

A byte-wide register port sets up the block. It holds the divisor low and high bytes, the prescaler value, the oversampling select, a control register whose top bit enables the prescaler, and an extended-mode register that unlocks that enable bit. A fractional ratio M + N/8 is built from whole input clock periods. In every group of eight prescaled pulses, the first N pulses are one input clock longer than the others. Any write to the divisor, prescaler or oversampling register restarts every counter, so the next period after such a write is always full length.

Top module: `baud_clk_gen`

## Requirements
- R1: After reset all six registers read 0 and both tick outputs are low while reset is asserted.
- R2: With the prescaler enabled, a prescaler value v >= 8 with M = v[7:3] and N = v[2:0] gives prescaled periods of M+1 input clocks for positions 0..N-1 and M input clocks for positions N..7 of each group of eight, counted from the last restart.
- R3: A prescaler value below 8 gives the same timing as value 8, a ratio of 1.
- R4: When the scaler-enable bit (bit 7 of the control register, address 2) is 0, the prescaler is bypassed and every input clock is a prescaled clock.
- R5: A write to the control register changes the scaler-enable bit only while bit 4 of the extended-mode register (address 3) is 1. Otherwise the bit keeps its value.
- R6: The scaler-enable bit stays in effect after extended mode is cleared, but then reads back as 0. It reads back as its value while extended mode is set.
- R7: The oversampling register (address 5) selects 16 sample ticks per bit for 0x00, 8 for 0x08 and 4 for 0x04. Any other value selects 16.
- R8: The divisor D is {high byte (address 1), low byte (address 0)}. sample_tick_o pulses once every D prescaled clocks, and D = 0 acts as D = 1.
- R9: bit_tick_o pulses together with every OS-th sample tick, where OS is the selected oversampling count, and never without a sample tick.
- R10: A write to address 0, 1, 4 or 5 restarts all counters. The k-th sample tick after that write comes exactly sum(first k*D prescaled periods) cycles after the write edge, and no output is asserted in the cycle right after the write.
- R11: The divisor bytes, prescaler (address 4) and oversampling register read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| sample_tick_o | output | 1 | One-cycle pulse per sample period |
| bit_tick_o | output | 1 | One-cycle pulse per bit period |

## Verification
A register write takes effect at the clock edge that samples it. Both tick outputs are registered, so a sample tick whose D-th prescaled clock completes in cycle index S-1 after the write edge appears in cycle index S. Here S is the sum of the first k*D prescaled periods, and a bit tick appears at the corresponding multiple of D*OS periods. The bench records the edge of each restarting write, logs the offset of every tick at the falling edge, and compares those offsets with sums computed from the R2 period rule. Read data is combinational and is checked shortly after the address settles.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OS_W   = 5;

  localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_EXT    = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRESC  = 3'd4;
  localparam logic [ADDR_W-1:0] A_OSR    = 3'd5;

  localparam int unsigned SCALE_EN_BIT = 7;
  localparam int unsigned EXT_EN_BIT   = 4;

  typedef enum logic [1:0] {OS_X16, OS_X8, OS_X4} os_mode_e;

  function automatic os_mode_e os_decode(logic [DATA_W-1:0] code);
    case (code)
      8'h08:   return OS_X8;
      8'h04:   return OS_X4;
      default: return OS_X16;
    endcase
  endfunction

  function automatic logic [OS_W-1:0] os_count(os_mode_e m);
    case (m)
      OS_X8:   return OS_W'(8);
      OS_X4:   return OS_W'(4);
      default: return OS_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/bclk_regs.sv
module bclk_regs
  import bclk_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] presc_o,
  output logic [DATA_W-1:0] osr_o,
  output logic              scale_en_o,
  output logic              restart_o
);
  logic [DATA_W-1:0] div_lo_q, div_hi_q, presc_q, osr_q, ext_q;
  logic [DATA_W-2:0] ctrl_low_q;
  logic              scale_en_q;
  logic              ext_on;

  assign ext_on = ext_q[EXT_EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_lo_q   <= '0;
      div_hi_q   <= '0;
      presc_q    <= '0;
      osr_q      <= '0;
      ext_q      <= '0;
      ctrl_low_q <= '0;
      scale_en_q <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        A_DIV_LO: div_lo_q <= wdata_i;
        A_DIV_HI: div_hi_q <= wdata_i;
        A_PRESC:  presc_q  <= wdata_i;
        A_OSR:    osr_q    <= wdata_i;
        A_EXT:    ext_q    <= wdata_i;
        A_CTRL: begin
          ctrl_low_q <= wdata_i[DATA_W-2:0];
          // enable bit is locked unless extended mode is on
          if (ext_on) scale_en_q <= wdata_i[SCALE_EN_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_DIV_LO: rdata_o = div_lo_q;
      A_DIV_HI: rdata_o = div_hi_q;
      A_PRESC:  rdata_o = presc_q;
      A_OSR:    rdata_o = osr_q;
      A_EXT:    rdata_o = ext_q;
      A_CTRL:   rdata_o = {scale_en_q & ext_on, ctrl_low_q};
      default:  rdata_o = '0;
    endcase
  end

  assign restart_o  = we_i && (addr_i == A_DIV_LO || addr_i == A_DIV_HI ||
                               addr_i == A_PRESC  || addr_i == A_OSR);
  assign div_o      = DIV_W'({div_hi_q, div_lo_q});
  assign presc_o    = presc_q;
  assign osr_o      = osr_q;
  assign scale_en_o = scale_en_q;

  // R5
  en_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_on |=> $stable(scale_en_q));
  // R6
  en_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL && !ext_on) |-> !rdata_o[SCALE_EN_BIT]);
endmodule

// File: rtl/bclk_prescale.sv
module bclk_prescale #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned FRAC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             bypass_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  localparam int unsigned INT_W = PRE_W - FRAC_W;
  localparam int unsigned CNT_W = INT_W + 1;
  localparam logic [PRE_W-1:0] UNITY = PRE_W'(1 << FRAC_W);

  logic [PRE_W-1:0]  eff;
  logic [INT_W-1:0]  m_part;
  logic [FRAC_W-1:0] n_part;
  logic [FRAC_W-1:0] phase_q;
  logic [CNT_W-1:0]  cnt_q, period;

  always_comb begin
    eff    = (presc_i < UNITY) ? UNITY : presc_i;
    m_part = eff[PRE_W-1:FRAC_W];
    n_part = eff[FRAC_W-1:0];
    // first n_part periods of each group are one clock longer
    period = {1'b0, m_part} + CNT_W'(phase_q < n_part);
    tick_o = bypass_i || (cnt_q == period - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (restart_i || bypass_i) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (tick_o) begin
      cnt_q   <= '0;
      phase_q <= phase_q + FRAC_W'(1);
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  cnt_in_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass_i |-> cnt_q < period);
  // R3
  unit_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc_i <= UNITY) |-> tick_o);
  // R4
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> tick_o);
endmodule

// File: rtl/bclk_divider.sv
module bclk_divider #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned OS_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             pre_tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [OS_W-1:0]  os_cnt_i,
  output logic             sample_tick_o,
  output logic             bit_tick_o
);
  logic [DIV_W-1:0] div_eff, sc_q;
  logic [OS_W-1:0]  bc_q;
  logic             samp_hit, bit_hit, sample_q, bit_q;

  always_comb begin
    div_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
    samp_hit = pre_tick_i && (sc_q == div_eff - DIV_W'(1));
    bit_hit  = samp_hit && (bc_q == os_cnt_i - OS_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q     <= '0;
      bc_q     <= '0;
      sample_q <= 1'b0;
      bit_q    <= 1'b0;
    end else if (restart_i) begin
      sc_q     <= '0;
      bc_q     <= '0;
      sample_q <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      if (pre_tick_i) sc_q <= samp_hit ? '0 : sc_q + DIV_W'(1);
      if (samp_hit)   bc_q <= bit_hit ? '0 : bc_q + OS_W'(1);
      sample_q <= samp_hit;
      bit_q    <= bit_hit;
    end
  end

  assign sample_tick_o = sample_q;
  assign bit_tick_o    = bit_q;

  // R8
  sc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_q < div_eff);
  // R9
  bc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_q < os_cnt_i);
  // R9
  bit_with_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);
  // R10
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!sample_tick_o && !bit_tick_o));
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import bclk_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sample_tick_o,
  output logic              bit_tick_o
);
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] presc, osr;
  logic              scale_en, restart, pre_tick;
  logic [OS_W-1:0]   os_cnt;

  bclk_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .div_o      (div),
    .presc_o    (presc),
    .osr_o      (osr),
    .scale_en_o (scale_en),
    .restart_o  (restart)
  );

  bclk_prescale #(.PRE_W(DATA_W), .FRAC_W(FRAC_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .bypass_i  (!scale_en),
    .presc_i   (presc),
    .tick_o    (pre_tick)
  );

  assign os_cnt = os_count(os_decode(osr));

  bclk_divider #(.DIV_W(DIV_W), .OS_W(OS_W)) u_div (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .restart_i     (restart),
    .pre_tick_i    (pre_tick),
    .div_i         (div),
    .os_cnt_i      (os_cnt),
    .sample_tick_o (sample_tick_o),
    .bit_tick_o    (bit_tick_o)
  );
endmodule

// File: tb/baud_clk_gen_tb.sv
`timescale 1ns/1ps
module baud_clk_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       sample_tick_o, bit_tick_o;

  int total = 0, bad = 0;
  int cyc = 0, wbase = 0;
  bit armed = 0, done = 0;
  int st[8], bt[2];
  int ns, nb;

  baud_clk_gen dut_i (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) if (armed) begin
    if (sample_tick_o && ns < 8) begin st[ns] = cyc - wbase; ns++; end
    if (bit_tick_o && nb < 2) begin bt[nb] = cyc - wbase; nb++; end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    #1;
    if (a == 0 || a == 1 || a == 4 || a == 5) wbase = cyc;
    reg_we_i = 0;
  endtask

  task automatic rd(logic [2:0] a, int exp, string req);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(req, reg_rdata_o, exp);
  endtask

  function automatic int per(int j, int pv, bit en);
    if (!en || pv < 8) return 1;
    return (pv >> 3) + (((j % 8) < (pv & 7)) ? 1 : 0);
  endfunction

  function automatic int tsum(int n, int pv, bit en);
    int s = 0;
    for (int j = 0; j < n; j++) s += per(j, pv, en);
    return s;
  endfunction

  function automatic int osn(int code);
    return (code == 8) ? 8 : (code == 4) ? 4 : 16;
  endfunction

  // en: expected prescaler state; writes pre, divisor, then oversampling (restart)
  task automatic run(int pv, int dv, int oc, bit en, string req);
    int d, os, horizon;
    wr(3'd4, 8'(pv));
    wr(3'd0, 8'(dv & 255));
    wr(3'd1, 8'(dv >> 8));
    for (int i = 0; i < 8; i++) st[i] = -1;
    bt[0] = -1; bt[1] = -1;
    ns = 0; nb = 0;
    armed = 1;
    wr(3'd5, 8'(oc));
    d = (dv == 0) ? 1 : dv;
    os = osn(oc);
    horizon = tsum(2 * d * os, pv, en);
    if (tsum(8 * d, pv, en) > horizon) horizon = tsum(8 * d, pv, en);
    while (cyc - wbase < horizon + 3) @(negedge clk_i);
    armed = 0;
    for (int k = 0; k < 8; k++) chk({req, " sample"}, st[k], tsum((k + 1) * d, pv, en));
    for (int k = 0; k < 2; k++) chk({req, " bit"}, bt[k], tsum((k + 1) * d * os, pv, en));
  endtask

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 tick", {31'd0, sample_tick_o | bit_tick_o}, 0);
    rst_ni = 1;
    for (int a = 0; a < 6; a++) rd(3'(a), 0, "R1");
    // R11 readback
    wr(3'd0, 8'h5A); wr(3'd1, 8'hC3); wr(3'd4, 8'h9E); wr(3'd5, 8'h08);
    rd(3'd0, 8'h5A, "R11"); rd(3'd1, 8'hC3, "R11");
    rd(3'd4, 8'h9E, "R11"); rd(3'd5, 8'h08, "R11");
    // R4 bypass: enable still 0 from reset
    run(8'h13, 2, 4, 0, "R4");
    // R5 write without extended mode ignored
    wr(3'd2, 8'h80);
    rd(3'd2, 0, "R5");
    run(8'h0D, 1, 4, 0, "R5");
    // enable with extended mode
    wr(3'd3, 8'h10); wr(3'd2, 8'h80);
    rd(3'd2, 8'h80, "R6");
    run(8'h08, 3, 0, 1, "R3 unity");
    run(8'h0D, 2, 4, 1, "R2 R10");
    run(8'h13, 1, 8, 1, "R2 R7");
    run(8'h05, 3, 4, 1, "R3");
    run(8'h0A, 0, 8'h0C, 1, "R8 R7");
    run(8'hFF, 1, 4, 1, "R2 max");
    // R6 latched after extended mode off
    wr(3'd3, 8'h00);
    rd(3'd2, 0, "R6");
    wr(3'd2, 8'h00);
    run(8'h0B, 2, 4, 1, "R6 R5");
    wr(3'd3, 8'h10);
    rd(3'd2, 8'h80, "R6");
    // clear enable, high divisor byte
    wr(3'd2, 8'h00);
    run(8'h0B, 257, 4, 0, "R8 R9");
    run(8'h0B, 3, 0, 0, "R9 R7");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule